// File: doc/BRIEF.md
# Private-Mode Memory Latency Estimator

This block runs next to a shared memory request queue whose scheduler reorders requests from many cores. It serves one core. It estimates how long that core's newest request would wait if the core had the memory bus to itself. It tracks only that core's own requests, in the order they arrived, and ignores the order in which the shared scheduler actually serves them. For each bank it keeps a register holding the row that would be open under private, in-order service. A new request takes the row-hit latency if its row matches that register and the row-miss latency otherwise. Both latency values are programmable.

Each accepted request's looked-up latency is stored in an eight-entry circular buffer. A running total of all stored latencies is kept up to date. The total is the estimate: it is the sum of the latencies of the requests ahead of the newest one, plus that request's own. A dequeue pops the oldest entry and subtracts its latency. Some requests exist only because the core shares the cache, such as misses caused by sharing and shared-cache writebacks. These are flagged at the input and leave no trace in the estimate.

Top module: `plme_top`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0, `occupancy`=0), `est_latency` is 0, and every bank's emulated open row is invalid, so the first accepted request to any bank is a row miss.
- R2: An accepted request whose bank holds no valid open row, or holds a different row, adds `lat_row_miss` to `est_latency`. The sum is visible one cycle after the enqueue edge.
- R3: An accepted request whose row equals the row of the most recent accepted request to the same bank adds `lat_row_hit` to `est_latency`.
- R4: `est_latency` always equals the sum of the stored latencies of all outstanding entries, and `occupancy` equals their number. When empty, the estimate is 0.
- R5: A dequeue on a non-empty buffer removes the oldest entry in arrival order. `est_latency` drops by that entry's stored latency in the next cycle.
- R6: An enqueue and a dequeue in the same cycle both take effect in that cycle. `occupancy` is unchanged and the total changes by the new latency minus the departing one.
- R7: With 8 entries outstanding, `full` is 1 and an enqueue is refused, even when a dequeue occurs in the same cycle. A refused enqueue changes neither the estimate nor any bank's open row.
- R8: An enqueue with `enq_shared_only`=1 is ignored. It changes no buffer entry, no total and no bank's open row.
- R9: A dequeue while the buffer is empty has no effect.
- R10: A request's latency is fixed when it is accepted. Later changes to `lat_row_hit` or `lat_row_miss` do not alter entries already stored.
- R11: Banks are independent. An access to one bank does not change the open row of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | New request from the tracked core |
| enq_shared_only | input | 1 | Request exists only because of sharing; exclude it |
| enq_bank | input | 2 | Bank index of the request |
| enq_row | input | 8 | Row index of the request |
| deq_valid | input | 1 | Oldest tracked request has been served |
| lat_row_hit | input | 8 | Programmable row-hit latency in cycles |
| lat_row_miss | input | 8 | Programmable row-miss latency in cycles |
| full | output | 1 | Buffer holds 8 entries; enqueue refused |
| empty | output | 1 | Buffer holds no entries |
| occupancy | output | 4 | Number of outstanding entries |
| est_latency | output | 12 | Estimated private-mode queue latency in cycles |

## Verification
A wrong open-row register has no direct output. It appears only at the next accepted request to that bank, whose contribution to `est_latency` is the wrong one of the two table values. For this reason the bench follows every stimulus that should leave bank state untouched with a probe request to the same bank. A corrupted head pointer or stored latency appears at the first dequeue of the affected entry, as a wrong decrement in the next cycle. A draining sequence that does not return the estimate to exactly 0 points to a stale or misordered entry.

// File: rtl/plme_pkg.sv
package plme_pkg;

    localparam int DEF_DEPTH     = 8;
    localparam int DEF_NUM_BANKS = 4;
    localparam int DEF_ROW_W     = 8;
    localparam int DEF_LAT_W     = 8;

    typedef enum logic {
        LK_MISS = 1'b0,
        LK_HIT  = 1'b1
    } lookup_e;

    function automatic lookup_e classify(input logic open_valid, input logic row_match);
        return (open_valid && row_match) ? LK_HIT : LK_MISS;
    endfunction

    function automatic int sum_width(input int lat_w, input int depth);
        return lat_w + $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/plme_bank_tbl.sv
module plme_bank_tbl
    import plme_pkg::*;
#(
    parameter int NUM_BANKS = DEF_NUM_BANKS,
    parameter int ROW_W     = DEF_ROW_W,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    input  logic              upd_en,
    output lookup_e           kind
);

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
    } open_row_t;

    open_row_t open_q [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[g] <= '0;
            end else if (upd_en && (look_bank == BANK_W'(g))) begin
                open_q[g].valid <= 1'b1;
                open_q[g].row   <= look_row;
            end
        end
    end

    open_row_t sel;
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (look_bank == BANK_W'(i)) sel = open_q[i];
        end
        kind = classify(sel.valid, sel.row == look_row);
    end

endmodule

// File: rtl/plme_lat_fifo.sv
module plme_lat_fifo #(
    parameter int DEPTH    = 8,
    parameter int LAT_W    = 8,
    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LAT_W-1:0] push_lat,
    input  logic             pop,
    output logic [LAT_W-1:0] head_lat,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [LAT_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    logic do_push, do_pop;

    assign full     = (count_q == CNT_W'(DEPTH));
    assign empty    = (count_q == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head_lat = slot_q[head_q];
    assign count    = count_q;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) tail_q <= wrap_inc(tail_q);
            if (do_pop)  head_q <= wrap_inc(head_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (do_push && (tail_q == PTR_W'(g))) begin
                slot_q[g] <= push_lat;
            end
        end
    end

endmodule

// File: rtl/plme_accum.sv
module plme_accum #(
    parameter int LAT_W = 8,
    parameter int SUM_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             add_en,
    input  logic [LAT_W-1:0] add_val,
    input  logic             sub_en,
    input  logic [LAT_W-1:0] sub_val,
    output logic [SUM_W-1:0] total
);

    logic [SUM_W-1:0] total_q;
    logic [SUM_W-1:0] inc, dec;

    assign inc   = add_en ? SUM_W'(add_val) : '0;
    assign dec   = sub_en ? SUM_W'(sub_val) : '0;
    assign total = total_q;

    always_ff @(posedge clk) begin
        if (rst) total_q <= '0;
        else     total_q <= total_q + inc - dec;
    end

endmodule

// File: rtl/plme_top.sv
module plme_top
    import plme_pkg::*;
#(
    parameter int DEPTH     = DEF_DEPTH,
    parameter int NUM_BANKS = DEF_NUM_BANKS,
    parameter int ROW_W     = DEF_ROW_W,
    parameter int LAT_W     = DEF_LAT_W,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int SUM_W    = sum_width(LAT_W, DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    input  logic              enq_shared_only,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic              deq_valid,
    input  logic [LAT_W-1:0]  lat_row_hit,
    input  logic [LAT_W-1:0]  lat_row_miss,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  occupancy,
    output logic [SUM_W-1:0]  est_latency
);

    lookup_e          kind;
    logic             accept, retire;
    logic [LAT_W-1:0] pick_lat, head_lat;

    assign accept   = enq_valid && !enq_shared_only && !full;
    assign retire   = deq_valid && !empty;
    assign pick_lat = (kind == LK_HIT) ? lat_row_hit : lat_row_miss;

    plme_bank_tbl #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_banks (
        .clk       (clk),
        .rst       (rst),
        .look_bank (enq_bank),
        .look_row  (enq_row),
        .upd_en    (accept),
        .kind      (kind)
    );

    plme_lat_fifo #(
        .DEPTH    (DEPTH),
        .LAT_W    (LAT_W)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .push_lat (pick_lat),
        .pop      (retire),
        .head_lat (head_lat),
        .count    (occupancy),
        .full     (full),
        .empty    (empty)
    );

    plme_accum #(
        .LAT_W   (LAT_W),
        .SUM_W   (SUM_W)
    ) u_accum (
        .clk     (clk),
        .rst     (rst),
        .add_en  (accept),
        .add_val (pick_lat),
        .sub_en  (retire),
        .sub_val (head_lat),
        .total   (est_latency)
    );

endmodule

// File: rtl/plme_checker.sv
module plme_checker #(
    parameter int DEPTH  = 8,
    parameter int LAT_W  = 8,
    parameter int CNT_W  = 4,
    parameter int SUM_W  = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_valid,
    input logic             enq_shared_only,
    input logic             deq_valid,
    input logic [LAT_W-1:0] lat_row_hit,
    input logic [LAT_W-1:0] lat_row_miss,
    input logic             full,
    input logic             empty,
    input logic [CNT_W-1:0] occupancy,
    input logic [SUM_W-1:0] est_latency
);

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        empty |-> est_latency == '0); // R4

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CNT_W'(DEPTH)); // R7

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        full && enq_valid && !deq_valid |=> full && $stable(est_latency)); // R7

    AST_SHARED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        enq_valid && enq_shared_only && !deq_valid
        |=> $stable(est_latency) && $stable(occupancy)); // R8

    AST_EMPTY_DEQ: assert property (@(posedge clk) disable iff (rst)
        empty && deq_valid && !enq_valid |=> empty && est_latency == '0); // R9

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        enq_valid && !enq_shared_only && !full && !deq_valid
        && lat_row_hit != '0 && lat_row_miss != '0
        |=> occupancy == $past(occupancy) + CNT_W'(1)
            && est_latency > $past(est_latency)); // R2

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        deq_valid && !empty && !enq_valid
        |=> occupancy == $past(occupancy) - CNT_W'(1)
            && est_latency <= $past(est_latency)); // R5

    AST_PAIR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        deq_valid && !empty && enq_valid && !enq_shared_only && !full
        |=> $stable(occupancy)); // R6

endmodule

bind plme_top plme_checker #(
    .DEPTH (DEPTH),
    .LAT_W (LAT_W),
    .CNT_W (CNT_W),
    .SUM_W (SUM_W)
) u_plme_checker (
    .clk             (clk),
    .rst             (rst),
    .enq_valid       (enq_valid),
    .enq_shared_only (enq_shared_only),
    .deq_valid       (deq_valid),
    .lat_row_hit     (lat_row_hit),
    .lat_row_miss    (lat_row_miss),
    .full            (full),
    .empty           (empty),
    .occupancy       (occupancy),
    .est_latency     (est_latency)
);

// File: tb/plme_top_bench.sv
module plme_top_bench;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0;
    logic        enq_shared_only = 1'b0;
    logic [1:0]  enq_bank = '0;
    logic [7:0]  enq_row = '0;
    logic        deq_valid = 1'b0;
    logic [7:0]  lat_row_hit = 8'd40;
    logic [7:0]  lat_row_miss = 8'd100;
    logic        full, empty;
    logic [3:0]  occupancy;
    logic [11:0] est_latency;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int mq[$];
    int mopen[NB];
    bit mval[NB];

    always #2 clk = ~clk;

    plme_top u_plme_top (
        .clk (clk), .rst (rst),
        .enq_valid (enq_valid), .enq_shared_only (enq_shared_only),
        .enq_bank (enq_bank), .enq_row (enq_row), .deq_valid (deq_valid),
        .lat_row_hit (lat_row_hit), .lat_row_miss (lat_row_miss),
        .full (full), .empty (empty), .occupancy (occupancy),
        .est_latency (est_latency)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_sum();
        int s = 0;
        foreach (mq[i]) s += mq[i];
        return s;
    endfunction

    task automatic check_state(input string tag);
        check_val({tag, " est"}, int'(est_latency), model_sum());
        check_val({tag, " occ"}, int'(occupancy), mq.size());
        check_val({tag, " full"}, int'(full), int'(mq.size() == 8));
        check_val({tag, " empty"}, int'(empty), int'(mq.size() == 0));
    endtask

    task automatic step(input bit e, input bit so, input int b, input int r,
                        input bit d, input string tag);
        bit acc;
        @(negedge clk);
        enq_valid = e; enq_shared_only = so;
        enq_bank = 2'(b); enq_row = 8'(r); deq_valid = d;
        @(posedge clk);
        acc = e && !so && (mq.size() < 8);
        if (d && mq.size() > 0) void'(mq.pop_front());
        if (acc) begin
            mq.push_back((mval[b] && mopen[b] == r) ? int'(lat_row_hit) : int'(lat_row_miss));
            mval[b] = 1'b1;
            mopen[b] = r;
        end
        #1;
        enq_valid = 1'b0; deq_valid = 1'b0; enq_shared_only = 1'b0;
        check_state(tag);
    endtask

    task automatic drain(input string tag);
        while (mq.size() > 0) step(0, 0, 0, 0, 1, tag);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mq.delete();
        for (int i = 0; i < NB; i++) begin mval[i] = 1'b0; mopen[i] = 0; end
        #1;
        check_state("R1 reset");
    endtask

    task automatic test_hit_miss();
        step(1, 0, 0, 5, 0, "R1 R2 first access miss");
        check_val("R2 est after first", int'(est_latency), 100);
        step(1, 0, 0, 5, 0, "R3 same row hit");
        check_val("R3 est", int'(est_latency), 140);
        step(1, 0, 0, 6, 0, "R2 other row miss");
        step(1, 0, 1, 6, 0, "R11 bank1 fresh miss");
        check_val("R11 est", int'(est_latency), 340);
        step(1, 0, 0, 6, 0, "R11 bank0 kept row hit");
        check_val("R11 est2", int'(est_latency), 380);
    endtask

    task automatic test_dequeue();
        step(0, 0, 0, 0, 1, "R5 pop oldest");
        check_val("R5 est", int'(est_latency), 280);
        step(0, 0, 0, 0, 1, "R5 pop second");
        check_val("R5 est2", int'(est_latency), 240);
        drain("R4 drain");
        check_val("R4 drained", int'(est_latency), 0);
    endtask

    task automatic test_empty_deq();
        step(0, 0, 0, 0, 1, "R9 deq empty");
        step(1, 0, 3, 2, 0, "R9 probe enq");
        drain("R9 drain");
    endtask

    task automatic test_full();
        for (int i = 0; i < 8; i++) step(1, 0, 2, 1, 0, "R7 fill");
        check_val("R7 full", int'(full), 1);
        step(1, 0, 2, 9, 0, "R7 refused");
        step(1, 0, 2, 9, 1, "R7 refused with deq");
        check_val("R7 occ after pair", int'(occupancy), 7);
        drain("R7 drain");
        step(1, 0, 2, 1, 0, "R7 bank kept row");
        check_val("R7 probe hit", int'(est_latency), 40);
        drain("R7 drain2");
    endtask

    task automatic test_shared();
        step(1, 1, 3, 4, 0, "R8 shared ignored");
        check_val("R8 est", int'(est_latency), 0);
        step(1, 0, 3, 4, 0, "R8 bank untouched");
        check_val("R8 probe", int'(est_latency), 100);
        drain("R8 drain");
    endtask

    task automatic test_pair();
        step(1, 0, 1, 7, 0, "R6 setup a");
        step(1, 0, 1, 7, 0, "R6 setup b");
        step(1, 0, 1, 8, 1, "R6 enq deq pair");
        check_val("R6 occ", int'(occupancy), 2);
        check_val("R6 est", int'(est_latency), 140);
        drain("R6 drain");
    endtask

    task automatic test_cfg();
        step(1, 0, 0, 20, 0, "R10 old miss");
        step(1, 0, 0, 20, 0, "R10 old hit");
        @(negedge clk);
        lat_row_hit = 8'd30; lat_row_miss = 8'd70;
        step(1, 0, 0, 21, 0, "R10 new miss");
        check_val("R10 est", int'(est_latency), 210);
        step(0, 0, 0, 0, 1, "R10 pop old");
        check_val("R10 est after pop", int'(est_latency), 110);
        drain("R10 drain");
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_hit_miss();
        test_dequeue();
        test_empty_deq();
        test_full();
        test_shared();
        test_pair();
        test_cfg();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule